// File: doc/BRIEF.md
# Differential Bit-Sliced Shift-Add Combiner

This block rebuilds the signed partial result of one output channel for a single input-bit iteration of an in-memory multiply-accumulate engine. Each weight is split across several cells that each hold two bits, so every output yields one digitized sample per cell. A single time-shared converter delivers these samples one at a time. The weights are kept in two separate arrays, one for the positive weights and one for the negative weights, and each array supplies its own set of samples.

The combiner shifts each sample left according to the significance of its cell, which means two bit positions per cell. It sums the shifted samples of each array and subtracts the negative-array total from the positive-array total. It then emits one signed partial result, tagged with its output channel. Channels are served in turn, and the result appears in the pipeline stage that follows the last conversion. A sample that arrives out of the expected order raises an error pulse, and the channel's collection restarts.

A two-state machine tracks the expected order. In state POS_COLLECT it takes positive-array slices, and in state NEG_COLLECT it takes negative-array slices. The transition POS_DONE (last positive slice accepted) moves it from POS_COLLECT to NEG_COLLECT. The transition CHAN_DONE (last negative slice accepted) returns it to POS_COLLECT and advances the channel. The transition ABORT (out-of-order sample) returns it to POS_COLLECT at slice 0 of the same channel. A valid in-order sample that is not the last slice of its array causes the transition SLICE_STEP, which keeps the state and advances the slice.

Top module: `shift_add_combiner`

## Requirements
- R1: After reset, `res_valid` and `seq_err` are low, and the first sample expected is slice 0 of the positive array (`smp_neg`=0) for channel 0.
- R2: A sample for slice k (k=0 is the least-significant cell) is weighted by 4^k, that is, shifted left by 2k bits, before it is summed with the other slices of the same array.
- R3: `res_value` is the two's-complement value of (sum over k of positive code_k·4^k) minus (sum over k of negative code_k·4^k). This holds for the extremes: all positive codes 255 with all negative codes 0, and the reverse.
- R4: For a channel, the expected order is positive slices 0..7 followed by negative slices 0..7, with `smp_neg`=1 marking the negative array. `res_valid` pulses for one cycle in the clock cycle after the last negative slice is accepted, and it stays low after every earlier sample.
- R5: `res_chan` carries the channel of the result. Channels are served 0,1,…,15 and then wrap back to 0.
- R6: A valid sample is out of order if its slice, its array flag or its channel differs from what is expected. Such a sample pulses `seq_err` one cycle later and gives no result. The partial sums are discarded, and the next expected sample is positive slice 0 of the same channel.
- R7: Cycles with `smp_valid` low have no effect. Outputs stay low during them, and a channel whose samples are separated by idle cycles gives the same result.
- R8: `res_valid` and `seq_err` are never high together, and neither is high unless a valid sample was presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A converter sample is present |
| smp_code | input | 8 | Unsigned converter code |
| smp_slice | input | 3 | Cell index, 0 = least significant |
| smp_neg | input | 1 | 0 = positive-weight array, 1 = negative-weight array |
| smp_chan | input | 4 | Output channel the sample belongs to |
| res_valid | output | 1 | One-cycle pulse: partial result ready |
| res_chan | output | 4 | Channel of the partial result |
| res_value | output | 26 | Signed partial result, two's complement |
| seq_err | output | 1 | One-cycle pulse: out-of-order sample |

## Verification
A wrong slice or phase counter inside the tracker appears at the ports within one sample. The next in-order sample then raises `seq_err`, or the last negative slice fails to produce `res_valid`. A wrong shift amount or a missing subtraction only appears when the channel completes, as a result that differs from the arithmetic value. For that reason the sweeps walk a single nonzero code through every slice of each array. A channel counter that is off shows as a mismatched `res_chan` on the very next result. It also shows as an error pulse on the first sample of the following channel.

// File: rtl/comb_pkg.sv
package comb_pkg;
    typedef enum logic {
        POS_COLLECT = 1'b0,
        NEG_COLLECT = 1'b1
    } trk_state_t;
endpackage

// File: rtl/slice_shifter.sv
module slice_shifter #(
    parameter int ADC_W     = 8,
    parameter int CELL_BITS = 2,
    parameter int NSLICE    = 8,
    localparam int SL_W     = (NSLICE > 1) ? $clog2(NSLICE) : 1,
    localparam int SH_W     = ADC_W + CELL_BITS * (NSLICE - 1)
) (
    input  logic [ADC_W-1:0] code,
    input  logic [SL_W-1:0]  slice,
    output logic [SH_W-1:0]  shifted
);
    logic [SH_W-1:0] cand [NSLICE];

    for (genvar k = 0; k < NSLICE; k++) begin : g_cand
        assign cand[k] = SH_W'(code) << (CELL_BITS * k);
    end

    always_comb begin
        shifted = '0;
        for (int k = 0; k < NSLICE; k++) begin
            if (slice == SL_W'(k)) shifted = cand[k];
        end
    end
endmodule

// File: rtl/order_tracker.sv
module order_tracker
    import comb_pkg::*;
#(
    parameter int NSLICE = 8,
    parameter int NCH    = 16,
    localparam int SL_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [SL_W-1:0] smp_slice,
    input  logic            smp_neg,
    input  logic [CH_W-1:0] smp_chan,
    output logic            take,
    output logic            first,
    output logic            neg_phase,
    output logic            done,
    output logic            bad,
    output logic [CH_W-1:0] cur_chan
);
    trk_state_t      state, state_nx;
    logic [SL_W-1:0] exp_slice, exp_slice_nx;
    logic [CH_W-1:0] exp_chan, exp_chan_nx;
    logic            match, last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= POS_COLLECT;
            exp_slice <= '0;
            exp_chan  <= '0;
        end else begin
            state     <= state_nx;
            exp_slice <= exp_slice_nx;
            exp_chan  <= exp_chan_nx;
        end
    end

    always_comb begin
        match        = (smp_slice == exp_slice) && (smp_chan == exp_chan)
                       && (smp_neg == (state == NEG_COLLECT));
        last         = (exp_slice == SL_W'(NSLICE - 1));
        take         = smp_valid && match;
        bad          = smp_valid && !match;
        first        = (exp_slice == '0);
        neg_phase    = (state == NEG_COLLECT);
        done         = 1'b0;
        cur_chan     = exp_chan;
        state_nx     = state;
        exp_slice_nx = exp_slice;
        exp_chan_nx  = exp_chan;
        if (bad) begin
            state_nx     = POS_COLLECT;
            exp_slice_nx = '0;
        end else if (take) begin
            unique case (state)
                POS_COLLECT: begin
                    if (last) begin
                        state_nx     = NEG_COLLECT;
                        exp_slice_nx = '0;
                    end else begin
                        exp_slice_nx = exp_slice + 1'b1;
                    end
                end
                NEG_COLLECT: begin
                    if (last) begin
                        done         = 1'b1;
                        state_nx     = POS_COLLECT;
                        exp_slice_nx = '0;
                        exp_chan_nx  = (exp_chan == CH_W'(NCH - 1)) ? '0 : exp_chan + 1'b1;
                    end else begin
                        exp_slice_nx = exp_slice + 1'b1;
                    end
                end
                default: state_nx = POS_COLLECT;
            endcase
        end
    end

    // R6: an out-of-order sample sends the tracker back to positive slice 0
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (state == POS_COLLECT && exp_slice == '0 && exp_chan == $past(exp_chan)));

    // R5: a completed channel moves the expected channel on
    a_r5_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (exp_chan != $past(exp_chan) || NCH == 1));
endmodule

// File: rtl/shift_add_combiner.sv
module shift_add_combiner #(
    parameter int ADC_W     = 8,
    parameter int CELL_BITS = 2,
    parameter int NSLICE    = 8,
    parameter int NCH       = 16,
    localparam int SL_W     = (NSLICE > 1) ? $clog2(NSLICE) : 1,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SH_W     = ADC_W + CELL_BITS * (NSLICE - 1),
    localparam int ACC_W    = SH_W + SL_W,
    localparam int RES_W    = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [ADC_W-1:0]        smp_code,
    input  logic [SL_W-1:0]         smp_slice,
    input  logic                    smp_neg,
    input  logic [CH_W-1:0]         smp_chan,
    output logic                    res_valid,
    output logic [CH_W-1:0]         res_chan,
    output logic signed [RES_W-1:0] res_value,
    output logic                    seq_err
);
    logic             take, first, neg_phase, done, bad;
    logic [CH_W-1:0]  cur_chan;
    logic [SH_W-1:0]  shifted;
    logic [ACC_W-1:0] acc_pos, acc_neg, neg_total;

    slice_shifter #(.ADC_W(ADC_W), .CELL_BITS(CELL_BITS), .NSLICE(NSLICE)) u_shift (
        .code(smp_code), .slice(smp_slice), .shifted(shifted)
    );

    order_tracker #(.NSLICE(NSLICE), .NCH(NCH)) u_track (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_slice(smp_slice),
        .smp_neg(smp_neg), .smp_chan(smp_chan), .take(take), .first(first),
        .neg_phase(neg_phase), .done(done), .bad(bad), .cur_chan(cur_chan)
    );

    assign neg_total = acc_neg + ACC_W'(shifted);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_pos   <= '0;
            acc_neg   <= '0;
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_value <= '0;
            seq_err   <= 1'b0;
        end else begin
            res_valid <= done;
            seq_err   <= bad;
            if (take && !neg_phase) acc_pos <= first ? ACC_W'(shifted) : acc_pos + ACC_W'(shifted);
            if (take && neg_phase)  acc_neg <= first ? ACC_W'(shifted) : neg_total;
            if (done) begin
                res_chan  <= cur_chan;
                res_value <= $signed({1'b0, acc_pos}) - $signed({1'b0, first ? ACC_W'(shifted) : neg_total});
            end
        end
    end

    // R8: result and error never pulse together
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && seq_err));

    // R7: an idle input cycle produces no output in the next cycle
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!res_valid && !seq_err));

    // R4: a result always follows the last negative-array slice
    a_r4_last_neg: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(smp_neg) && $past(smp_slice) == SL_W'(NSLICE - 1)));
endmodule

// File: tb/test_shift_add_combiner.sv
module test_shift_add_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_code = '0;
    logic [2:0]  smp_slice = '0;
    logic        smp_neg = 1'b0;
    logic [3:0]  smp_chan = '0;
    logic        res_valid, seq_err;
    logic [3:0]  res_chan;
    logic signed [25:0] res_value;

    int n_chk = 0, n_err = 0, exp_ch = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shift_add_combiner i_shift_add_combiner (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .smp_slice(smp_slice), .smp_neg(smp_neg), .smp_chan(smp_chan),
        .res_valid(res_valid), .res_chan(res_chan), .res_value(res_value), .seq_err(seq_err)
    );

    task automatic chk(input string tag, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send(input logic [7:0] code, input int sl, input bit ng, input int ch);
        @(negedge clk);
        smp_valid = 1'b1; smp_code = code; smp_slice = 3'(sl); smp_neg = ng; smp_chan = 4'(ch);
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            chk("R7 idle no output", {res_valid, seq_err}, 0);
        end
    endtask

    task automatic run_chan(input logic [63:0] pc, input logic [63:0] nc, input int gap);
        longint e = 0;
        for (int k = 0; k < 8; k++) e += longint'(pc[8*k+:8]) << (2*k);
        for (int k = 0; k < 8; k++) e -= longint'(nc[8*k+:8]) << (2*k);
        for (int a = 0; a < 2; a++) begin
            for (int k = 0; k < 8; k++) begin
                send(a == 0 ? pc[8*k+:8] : nc[8*k+:8], k, a[0], exp_ch);
                if (a == 1 && k == 7) begin
                    chk("R4 valid after last neg slice", res_valid, 1);
                    chk("R8 no err with result", seq_err, 0);
                    chk("R5 result channel", res_chan, exp_ch);
                    chk("R3 R2 result value", longint'(res_value), e);
                end else begin
                    chk("R4 no output mid channel", {res_valid, seq_err}, 0);
                end
                if (gap > 0) idle(gap);
            end
        end
        exp_ch = (exp_ch + 1) % 16;
    endtask

    task automatic bad_after(input int n_good, input int sl, input bit ng, input int ch);
        for (int k = 0; k < n_good; k++) begin
            send(8'(k * 29 + 7), k % 8, k >= 8, exp_ch);
            chk("R6 good prefix quiet", {res_valid, seq_err}, 0);
        end
        send(8'hA5, sl, ng, ch);
        chk("R6 error pulse", seq_err, 1);
        chk("R6 no result on error", res_valid, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] p, q;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset res_valid", res_valid, 0);
        chk("R1 reset seq_err", seq_err, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        // R1: first channel is 0 (checked in run_chan); R5 wrap by 20 channels
        for (int c = 0; c < 20; c++) begin
            for (int k = 0; k < 8; k++) begin
                p[8*k+:8] = 8'(c * 37 + k * 11 + 3);
                q[8*k+:8] = 8'(c * 53 + k * 7 + 91);
            end
            run_chan(p, q, 0);
        end
        // R3 extremes
        run_chan({8{8'hFF}}, 64'h0, 0);
        run_chan(64'h0, {8{8'hFF}}, 0);
        run_chan(64'h0, 64'h0, 0);
        // R2 walk a single code through every slice of each array
        for (int k = 0; k < 8; k++) begin
            p = '0; q = '0; p[8*k+:8] = 8'd1; run_chan(p, q, 0);
            p = '0; q[8*k+:8] = 8'd3;          run_chan(p, q, 0);
        end
        // R7 gaps between samples
        run_chan(64'h0123456789ABCDEF, 64'h0F1E2D3C4B5A6978, 2);
        // R6 wrong slice, wrong array, wrong channel, positive sample in neg phase
        bad_after(2, 3, 1'b0, exp_ch);
        run_chan(64'h1111111111111111, 64'h0202020202020202, 0);
        bad_after(0, 0, 1'b1, exp_ch);
        run_chan(64'h8080808080808080, 64'h7F7F7F7F7F7F7F7F, 0);
        bad_after(5, 5, 1'b0, (exp_ch + 1) % 16);
        run_chan(64'hFEDCBA9876543210, 64'h0, 0);
        bad_after(11, 3, 1'b0, exp_ch);
        run_chan(64'h00000000000000FF, 64'hFF00000000000000, 0);
        idle(3);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule